// File: doc/BRIEF.md
# Averaged-Sample Limit Alert Engine

This block watches the averaged telemetry of one power rail: a signed current, a bus voltage and a power value. Each averaged sample arrives with a one-cycle valid strobe. The block compares every sample against programmable limits and keeps one status bit per fault cause. It drives an active-low alert line built to share a wired-OR interrupt net with other devices.

Current is bidirectional, so it has two limits. One limit covers charge (positive) current and the other covers discharge (negative) current, and each has its own status bit. Voltage and power each have one upper limit. A hysteresis value applies to each quantity, and charge and discharge share the current hysteresis.

A debounce setting filters short excursions: a fault must persist over several consecutive samples before its bit is set. The host selects one of two modes:
- **Latched mode:** a set bit holds until the host clears it.
- **Transparent mode:** a set bit drops by itself once the value comes back inside the limit with margin to spare.

Each cause runs a small state machine with three states:
- **ST_IDLE:** no fault pending.
- **ST_COUNT:** consecutive violations are being counted.
- **ST_FLAG:** the status bit is set.

The transitions between them are:
- ST_IDLE to ST_FLAG on a violating sample when the debounce setting is 0.
- ST_IDLE to ST_COUNT on a violating sample when the debounce setting is above 0.
- ST_COUNT to ST_COUNT on a violation while the count is below the setting.
- ST_COUNT to ST_FLAG on the violation that brings the run to the setting plus one.
- ST_COUNT to ST_IDLE on any non-violating sample.
- ST_FLAG to ST_IDLE on a release sample in transparent mode.
- ST_FLAG to ST_IDLE on an accepted host clear in latched mode.

Top module: `alert_engine`

## Requirements
- R1: After reset all four status bits are 0 and `alert_n` is 1.
- R2: Inputs are evaluated only in cycles where `smp_valid` is 1. Values presented without the strobe never change status.
- R3: A violation is a value strictly above its limit. With debounce setting D, a cause's bit sets on the (D+1)-th consecutive violating sample, so D=0 sets it on the first violating sample. Any non-violating sample restarts the count.
- R4: With `latch_mode`=1, a set bit stays set across non-violating samples until `host_clr` is pulsed. A clear is accepted only if the most recent sample did not violate that cause. Otherwise the clear is ignored and the bit stays set.
- R5: With `latch_mode`=0, a set bit drops at the first sample whose value is strictly below limit minus hysteresis. At values from limit minus hysteresis up to the limit, the bit stays set. `host_clr` has no effect in this mode.
- R6: The status bits are assigned as follows. Bit 0 is charge: current > 0 and current > `lim_chg`. Bit 1 is discharge: current < 0 and its magnitude > `lim_dsg`. Bit 2 is voltage, against `lim_volt`. Bit 3 is power, against `lim_pwr`. Charge and discharge both use `hyst_cur`.
- R7: `alert_n` is 0 exactly when some status bit i is 1 while `mask[i]` is 0. Masking a cause removes it from `alert_n` but still leaves its status bit visible.
- R8: A changed limit takes effect at the next valid sample and never clears a bit that is already latched.
- R9: If `smp_valid` and `host_clr` arrive in the same cycle, the sample is evaluated and the clear is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | One-cycle strobe that marks a new averaged sample |
| cur_avg | input | DW | Averaged current, two's complement, positive = charge |
| volt_avg | input | DW | Averaged bus voltage, unsigned |
| pwr_avg | input | DW | Averaged power, unsigned |
| lim_chg | input | DW | Charge current limit |
| lim_dsg | input | DW | Discharge current magnitude limit |
| lim_volt | input | DW | Voltage limit |
| lim_pwr | input | DW | Power limit |
| hyst_cur | input | DW | Release margin for both current causes |
| hyst_volt | input | DW | Release margin for voltage |
| hyst_pwr | input | DW | Release margin for power |
| debounce | input | CNTW | Number of extra consecutive violations required |
| latch_mode | input | 1 | 1 = latched, 0 = transparent |
| mask | input | 4 | Per-cause exclusion from the alert line |
| host_clr | input | 1 | Host clear strobe for latched bits |
| status | output | 4 | Per-cause status bits |
| alert_n | output | 1 | Active-low alert for a wired-OR line |

## Verification
The bench sweeps the debounce setting against run lengths of violations. A design that counts off by one would trip a sample early or late, and one that fails to restart its count after a clean sample would trip on scattered violations. A hysteresis sweep walks the release value across the limit-minus-margin boundary. This catches an inclusive comparison, which would drop the bit one code early, and a comparison against the bare limit, which would drop it at once. The latched tests cover several cases that a careless design would get wrong:
- A clear issued while the fault is still present must be ignored.
- A clear that coincides with a sample must be ignored.
- Raising a limit must not clear a held bit.

A swapped sign between the charge and discharge causes, or a mask that hides the status bit itself, shows up as the wrong bit pattern.

// File: rtl/alert_pkg.sv
package alert_pkg;
    localparam int NCAUSE = 4;

    typedef enum int unsigned {
        CAUSE_CHG  = 0,
        CAUSE_DSG  = 1,
        CAUSE_VOLT = 2,
        CAUSE_PWR  = 3
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FLAG  = 2'd2
    } cause_state_e;
endpackage

// File: rtl/alert_cmp.sv
module alert_cmp #(
    parameter int DW = 16,
    localparam int MW = DW + 1
) (
    input  logic [MW-1:0] mag,
    input  logic [DW-1:0] lim,
    input  logic [DW-1:0] hyst,
    output logic          viol,
    output logic          rel
);
    logic [MW:0] mag_x;
    logic [MW:0] lim_x;
    logic [MW:0] sum_x;

    always_comb begin
        mag_x = {1'b0, mag};
        lim_x = {2'b00, lim};
        sum_x = mag_x + {2'b00, hyst};
        viol  = mag_x > lim_x;
        rel   = sum_x < lim_x;
    end
endmodule

// File: rtl/alert_cause_fsm.sv
module alert_cause_fsm
    import alert_pkg::*;
#(
    parameter int CNTW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_valid,
    input  logic            viol,
    input  logic            rel,
    input  logic            latch_mode,
    input  logic            host_clr,
    input  logic [CNTW-1:0] debounce,
    output logic            flag
);
    cause_state_e    state_q, state_d;
    logic [CNTW-1:0] cnt_q, cnt_d;
    logic            last_viol_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            last_viol_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (smp_valid) begin
                last_viol_q <= viol;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (smp_valid && viol) begin
                    if (debounce == '0) begin
                        state_d = ST_FLAG;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_COUNT;
                        cnt_d   = CNTW'(1);
                    end
                end
            end
            ST_COUNT: begin
                if (smp_valid) begin
                    if (!viol) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else if (cnt_q >= debounce) begin
                        state_d = ST_FLAG;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNTW'(1);
                    end
                end
            end
            ST_FLAG: begin
                if (smp_valid) begin
                    if (!latch_mode && rel) begin
                        state_d = ST_IDLE;
                    end
                end else if (host_clr && latch_mode && !last_viol_q) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        flag = (state_q == ST_FLAG);
    end
endmodule

// File: rtl/alert_engine.sv
module alert_engine
    import alert_pkg::*;
#(
    parameter int DW   = 16,
    parameter int CNTW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] cur_avg,
    input  logic        [DW-1:0] volt_avg,
    input  logic        [DW-1:0] pwr_avg,
    input  logic        [DW-1:0] lim_chg,
    input  logic        [DW-1:0] lim_dsg,
    input  logic        [DW-1:0] lim_volt,
    input  logic        [DW-1:0] lim_pwr,
    input  logic        [DW-1:0] hyst_cur,
    input  logic        [DW-1:0] hyst_volt,
    input  logic        [DW-1:0] hyst_pwr,
    input  logic      [CNTW-1:0] debounce,
    input  logic                 latch_mode,
    input  logic    [NCAUSE-1:0] mask,
    input  logic                 host_clr,
    output logic    [NCAUSE-1:0] status,
    output logic                 alert_n
);
    localparam int MW = DW + 1;

    logic signed [DW:0] cur_x;
    logic signed [DW:0] cur_neg;
    logic [MW-1:0]      mag  [NCAUSE];
    logic [DW-1:0]      lim  [NCAUSE];
    logic [DW-1:0]      hyst [NCAUSE];
    logic [NCAUSE-1:0]  viol;
    logic [NCAUSE-1:0]  rel;

    always_comb begin
        cur_x   = {cur_avg[DW-1], cur_avg};
        cur_neg = -cur_x;
        mag[CAUSE_CHG]   = cur_x[DW] ? '0 : $unsigned(cur_x);
        mag[CAUSE_DSG]   = cur_x[DW] ? $unsigned(cur_neg) : '0;
        mag[CAUSE_VOLT]  = {1'b0, volt_avg};
        mag[CAUSE_PWR]   = {1'b0, pwr_avg};
        lim[CAUSE_CHG]   = lim_chg;
        lim[CAUSE_DSG]   = lim_dsg;
        lim[CAUSE_VOLT]  = lim_volt;
        lim[CAUSE_PWR]   = lim_pwr;
        hyst[CAUSE_CHG]  = hyst_cur;
        hyst[CAUSE_DSG]  = hyst_cur;
        hyst[CAUSE_VOLT] = hyst_volt;
        hyst[CAUSE_PWR]  = hyst_pwr;
    end

    for (genvar g = 0; g < NCAUSE; g++) begin : g_cause
        alert_cmp #(.DW(DW)) u_cmp (
            .mag  (mag[g]),
            .lim  (lim[g]),
            .hyst (hyst[g]),
            .viol (viol[g]),
            .rel  (rel[g])
        );

        alert_cause_fsm #(.CNTW(CNTW)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .smp_valid  (smp_valid),
            .viol       (viol[g]),
            .rel        (rel[g]),
            .latch_mode (latch_mode),
            .host_clr   (host_clr),
            .debounce   (debounce),
            .flag       (status[g])
        );
    end

    assign alert_n = ~|(status & ~mask);
endmodule

// File: rtl/alert_engine_chk.sv
module alert_engine_chk #(
    parameter int DW   = 16,
    parameter int CNTW = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 smp_valid,
    input logic signed [DW-1:0] cur_avg,
    input logic        [DW-1:0] volt_avg,
    input logic        [DW-1:0] lim_volt,
    input logic      [CNTW-1:0] debounce,
    input logic                 latch_mode,
    input logic                 host_clr,
    input logic           [3:0] status,
    input logic                 alert_n
);
    for (genvar i = 0; i < 4; i++) begin : g_bit
        AST_SET_ONLY_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[i]) |-> $past(smp_valid)); // R2
        AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(status[i]) && $past(latch_mode)) |-> ($past(host_clr) && !$past(smp_valid))); // R4
        AST_TRANSP_SELF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(status[i]) && !$past(latch_mode)) |-> $past(smp_valid)); // R5
    end

    AST_ZERO_DEBOUNCE: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && debounce == '0 && volt_avg > lim_volt) |=> status[2]); // R3
    AST_CHG_DSG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(status[0]) && $rose(status[1]))); // R6
    AST_ALERT_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_n |-> (status != 4'b0000)); // R7
endmodule

bind alert_engine alert_engine_chk #(.DW(DW), .CNTW(CNTW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .cur_avg    (cur_avg),
    .volt_avg   (volt_avg),
    .lim_volt   (lim_volt),
    .debounce   (debounce),
    .latch_mode (latch_mode),
    .host_clr   (host_clr),
    .status     (status),
    .alert_n    (alert_n)
);

// File: tb/tb_alert_engine.sv
module tb_alert_engine;
    localparam int DW   = 8;
    localparam int CNTW = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_valid = 1'b0;
    logic signed [DW-1:0] cur_avg = '0;
    logic        [DW-1:0] volt_avg = '0;
    logic        [DW-1:0] pwr_avg = '0;
    logic        [DW-1:0] lim_chg = 8'd50;
    logic        [DW-1:0] lim_dsg = 8'd50;
    logic        [DW-1:0] lim_volt = 8'd100;
    logic        [DW-1:0] lim_pwr = 8'd100;
    logic        [DW-1:0] hyst_cur = '0;
    logic        [DW-1:0] hyst_volt = '0;
    logic        [DW-1:0] hyst_pwr = '0;
    logic      [CNTW-1:0] debounce = '0;
    logic                 latch_mode = 1'b0;
    logic           [3:0] mask = '0;
    logic                 host_clr = 1'b0;
    logic           [3:0] status;
    logic                 alert_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alert_engine #(.DW(DW), .CNTW(CNTW)) dut (.*);

    function automatic logic [4:0] exp5(logic [3:0] s);
        return {((s & ~mask) == 4'b0000), s};
    endfunction

    task automatic chk(string req, logic [3:0] s_exp);
        logic [4:0] act;
        logic [4:0] ex;
        act = {alert_n, status};
        ex  = exp5(s_exp);
        total++;
        if (act !== ex) begin
            bad++;
            $display("FAIL %s: {alert_n,status} actual=%b expected=%b", req, act, ex);
        end
    endtask

    task automatic sample(int c, int v, int p, bit clr = 1'b0);
        @(negedge clk);
        cur_avg   = DW'(c);
        volt_avg  = DW'(v);
        pwr_avg   = DW'(p);
        smp_valid = 1'b1;
        host_clr  = clr;
        @(negedge clk);
        smp_valid = 1'b0;
        host_clr  = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        host_clr = 1'b1;
        @(negedge clk);
        host_clr = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 4'b0000);

        // R2: no strobe, no evaluation
        @(negedge clk);
        volt_avg = 8'd200;
        repeat (3) @(negedge clk);
        chk("R2 no strobe", 4'b0000);
        volt_avg = 8'd0;

        // R3: debounce sweep
        for (int d = 0; d < 4; d++) begin
            for (int len = 1; len <= 5; len++) begin
                debounce = CNTW'(d);
                sample(0, 0, 0);
                for (int k = 0; k < len; k++) sample(0, 120, 0);
                chk($sformatf("R3 d=%0d run=%0d", d, len), (len > d) ? 4'b0100 : 4'b0000);
            end
        end
        sample(0, 0, 0);
        debounce = 3'd2;
        sample(0, 120, 0);
        sample(0, 120, 0);
        sample(0, 100, 0);
        sample(0, 120, 0);
        sample(0, 120, 0);
        chk("R3 count restart", 4'b0000);
        sample(0, 120, 0);
        chk("R3 third in row", 4'b0100);
        sample(0, 0, 0);
        debounce = 3'd0;

        // R5: hysteresis sweep in transparent mode
        for (int hi = 0; hi < 3; hi++) begin
            hyst_volt = DW'(hi * 4 + hi);
            for (int x = 85; x <= 101; x++) begin
                sample(0, 120, 0);
                sample(0, x, 0);
                chk($sformatf("R5 h=%0d x=%0d", hi * 5, x),
                    (x + hi * 5 < 100) ? 4'b0000 : 4'b0100);
            end
            sample(0, 0, 0);
        end
        hyst_volt = '0;
        sample(0, 120, 0);
        pulse_clr();
        chk("R5 clear ignored transparent", 4'b0100);
        sample(0, 0, 0);

        // R6: cause separation
        hyst_cur = 8'd5;
        sample(60, 0, 0);
        chk("R6 charge", 4'b0001);
        sample(0, 0, 0);
        sample(-60, 0, 0);
        chk("R6 discharge", 4'b0010);
        sample(-47, 0, 0);
        chk("R6 discharge hysteresis hold", 4'b0010);
        sample(-40, 0, 0);
        chk("R6 discharge release", 4'b0000);
        sample(-50, 0, 50);
        chk("R6 at limit", 4'b0000);
        sample(-128, 0, 101);
        chk("R6 full negative and power", 4'b1010);
        sample(0, 0, 0);
        hyst_cur = '0;

        // R7: masking
        sample(0, 0, 150);
        mask = 4'b1000;
        @(negedge clk);
        chk("R7 masked power", 4'b1000);
        mask = 4'b0100;
        @(negedge clk);
        chk("R7 other bit masked", 4'b1000);
        mask = 4'b0000;
        sample(0, 0, 0);
        chk("R7 all clear", 4'b0000);

        // R4: latched mode
        latch_mode = 1'b1;
        sample(0, 120, 0);
        sample(0, 50, 0);
        chk("R4 latched holds", 4'b0100);
        sample(0, 120, 0);
        pulse_clr();
        chk("R4 clear during fault ignored", 4'b0100);
        sample(0, 100, 0);
        chk("R4 still held", 4'b0100);
        pulse_clr();
        chk("R4 clear accepted", 4'b0000);

        // R9: sample and clear together
        sample(0, 120, 0);
        sample(0, 0, 0, 1'b1);
        chk("R9 clear with sample ignored", 4'b0100);
        pulse_clr();
        chk("R9 clear alone", 4'b0000);

        // R8: limit change
        sample(0, 120, 0);
        @(negedge clk);
        lim_volt = 8'd200;
        @(negedge clk);
        chk("R8 limit write keeps latch", 4'b0100);
        sample(0, 150, 0);
        chk("R8 latched after new limit", 4'b0100);
        pulse_clr();
        chk("R8 clear under new limit", 4'b0000);
        latch_mode = 1'b0;
        sample(0, 150, 0);
        chk("R8 new limit used", 4'b0000);
        lim_volt = 8'd140;
        @(negedge clk);
        chk("R8 no effect before sample", 4'b0000);
        sample(0, 150, 0);
        chk("R8 effect at sample", 4'b0100);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule